// File: doc/BRIEF.md
# Receive FIFO Reader with Alignment Padding

This block holds a receive data queue of 32-bit words and a companion queue of per-packet lengths, and hands packets to a host one DWORD per read strobe. Once the real words of a packet have been delivered, it keeps answering reads with zero-valued filler words until the number of words handed out for that packet is a multiple of the programmed boundary (4, 16 or 32 bytes). The host throws the filler away. This keeps each buffer ending on a cache-line-friendly boundary.

A single configuration word carries three fields. The alignment select is in bits 31:30. A 12-bit DMA word count is in bits 27:16. A write-one discard strobe is in bit 15. The count runs down by one for every word the host takes, filler included. When it reaches zero, a one-cycle interrupt pulse is raised. The discard strobe empties both queues at once.

Top module: `rx_pad_reader`

## Requirements
- R1: After reset, cfg_rdata is zero, rd_valid, dma_irq and dat_full are low, and the alignment and DMA count are zero.
- R2: Each accepted read (host_rd while rd_valid) of a real word returns the data words in push order. A packet's length (1 to the data depth, in DWORDs) comes from the oldest sts_len entry.
- R3: After a packet's last real word, reads return 32'h0 and pop nothing. They continue until the words delivered for that packet total a multiple of N. N is 1 for select 00, 4 for 01 and 8 for 10.
- R4: Alignment select 11 gives no filler words, the same as 00.
- R5: The alignment in force for a packet is the one programmed when its first word is read. A configuration write during the packet does not change that packet's filler count.
- R6: A configuration write loads the DMA count from bits 27:16. Each accepted read, real or filler, decrements a nonzero count. The count reads back in cfg_rdata[27:16], and a rewrite replaces the running value.
- R7: dma_irq is high for exactly the one cycle after the accepted read that takes the count from 1 to 0. Reads at count 0 raise no pulse.
- R8: A configuration write with bit 15 set empties both queues, which drives rd_valid and dat_full low, and aborts any packet in progress. Words pushed afterwards are the first to be read. Bit 15 always reads back as 0.
- R9: host_last is high during the accepted read that delivers the final word, real or filler, of a packet's padded buffer.
- R10: host_rd while rd_valid is low is ignored and leaves the DMA count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: [31:30] alignment, [27:16] DMA count, [15] discard |
| cfg_rdata | output | 32 | Configuration readback; bit 15 is always 0 |
| dat_push | input | 1 | Push one received data word |
| dat_wdata | input | 32 | Received data word |
| dat_full | output | 1 | Data queue full |
| sts_push | input | 1 | Push one packet length |
| sts_len | input | LEN_W | Packet length in DWORDs |
| sts_full | output | 1 | Length queue full |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Word for the current read (zero for filler) |
| host_last | output | 1 | Current word ends the padded buffer |
| rd_valid | output | 1 | A word is available to read |
| dma_irq | output | 1 | One-cycle DMA count-done pulse |

## Verification
A wrong remaining-word counter shows at the very next read: either host_last marks the wrong word, or real data turns into zeros or the reverse. An error in the filler count shows within at most seven reads, when rd_valid stays high or drops at the wrong word. A wrong DMA count shows in cfg_rdata one cycle after the read, and a missed or doubled decrement moves the interrupt pulse by a cycle. A discard that leaves stale pointers shows when the first word read after new pushes is old data.

// File: rtl/rx_pad_reader.sv
module rx_pad_reader #(
  parameter int DAT_AW = 4,
  parameter int STS_AW = 2,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dat_push,
  input  logic [31:0]       dat_wdata,
  output logic              dat_full,
  input  logic              sts_push,
  input  logic [LEN_W-1:0]  sts_len,
  output logic              sts_full,
  input  logic              host_rd,
  output logic [31:0]       host_rdata,
  output logic              host_last,
  output logic              rd_valid,
  output logic              dma_irq
);
  localparam int DAT_D = 1 << DAT_AW;
  localparam int STS_D = 1 << STS_AW;

  logic [31:0]      dmem [DAT_D];
  logic [LEN_W-1:0] smem [STS_D];
  logic [DAT_AW:0]  dwp, drp;
  logic [STS_AW:0]  swp, srp;
  logic [1:0]       align_q;
  logic [CNT_W-1:0] cnt;
  logic             in_pkt;
  logic [LEN_W-1:0] data_left;
  logic [2:0]       pad_left;

  wire flush     = cfg_we & cfg_wdata[15];
  wire dat_empty = (dwp == drp);
  wire sts_empty = (swp == srp);
  assign dat_full = (dwp[DAT_AW] != drp[DAT_AW]) && (dwp[DAT_AW-1:0] == drp[DAT_AW-1:0]);
  assign sts_full = (swp[STS_AW] != srp[STS_AW]) && (swp[STS_AW-1:0] == srp[STS_AW-1:0]);

  wire [LEN_W-1:0] head_len = smem[srp[STS_AW-1:0]];
  wire [LEN_W-1:0] neg_len  = -head_len;
  wire [2:0]       pad_mask = (align_q == 2'b01) ? 3'd3 : (align_q == 2'b10) ? 3'd7 : 3'd0;
  wire [2:0]       new_pad  = neg_len[2:0] & pad_mask;
  wire [LEN_W-1:0] left_sum = data_left + LEN_W'(pad_left);

  assign rd_valid = in_pkt | ~sts_empty;
  wire rd_ok   = host_rd & rd_valid;
  wire is_data = in_pkt ? (data_left != '0) : 1'b1;
  wire pop_dat = rd_ok & is_data;
  wire pop_sts = rd_ok & ~in_pkt;

  assign host_rdata = (rd_valid && is_data) ? dmem[drp[DAT_AW-1:0]] : 32'h0;
  assign host_last  = rd_valid & (in_pkt ? (left_sum == LEN_W'(1))
                                         : (head_len == LEN_W'(1) && new_pad == 3'd0));
  assign cfg_rdata  = {align_q, 2'b00, cnt, 16'h0000};

  always_ff @(posedge clk) begin
    if (dat_push && !dat_full) dmem[dwp[DAT_AW-1:0]] <= dat_wdata;
    if (sts_push && !sts_full) smem[swp[STS_AW-1:0]] <= sts_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      dwp <= '0;
      drp <= '0;
      swp <= '0;
      srp <= '0;
    end else begin
      if (dat_push && !dat_full) dwp <= dwp + 1'b1;
      if (sts_push && !sts_full) swp <= swp + 1'b1;
      if (pop_dat) drp <= drp + 1'b1;
      if (pop_sts) srp <= srp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      in_pkt    <= 1'b0;
      data_left <= '0;
      pad_left  <= '0;
    end else if (rd_ok) begin
      if (!in_pkt) begin
        data_left <= head_len - 1'b1;
        pad_left  <= new_pad;
        in_pkt    <= (head_len != LEN_W'(1)) || (new_pad != 3'd0);
      end else begin
        if (data_left != '0) data_left <= data_left - 1'b1;
        else                 pad_left  <= pad_left - 1'b1;
        in_pkt <= (left_sum != LEN_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_q <= 2'b00;
      cnt     <= '0;
      dma_irq <= 1'b0;
    end else begin
      dma_irq <= rd_ok && !cfg_we && (cnt == CNT_W'(1));
      if (cfg_we) begin
        align_q <= cfg_wdata[31:30];
        cnt     <= cfg_wdata[16 +: CNT_W];
      end else if (rd_ok && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_dat |-> !dat_empty); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !cfg_we && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
  AST_IGNORED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rd_valid && !cfg_we) |=> $stable(cnt)); // R10
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |=> !dma_irq); // R7
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_irq) |-> (cnt == '0)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_valid && !dat_full)); // R8
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && host_last && !flush) |=> !in_pkt); // R9
endmodule

// File: tb/rx_pad_reader_bench.sv
module rx_pad_reader_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dat_push = 0;
  logic [31:0] dat_wdata = '0;
  logic        dat_full;
  logic        sts_push = 0;
  logic [11:0] sts_len = '0;
  logic        sts_full;
  logic        host_rd = 0;
  logic [31:0] host_rdata;
  logic        host_last;
  logic        rd_valid;
  logic        dma_irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rx_pad_reader u_rx_pad_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dat_push(dat_push), .dat_wdata(dat_wdata), .dat_full(dat_full),
    .sts_push(sts_push), .sts_len(sts_len), .sts_full(sts_full),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_last(host_last),
    .rd_valid(rd_valid), .dma_irq(dma_irq));

  // {align[25:24], len[23:12], expected total reads[11:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'b00, 12'd1, 12'd1}, {2'b00, 12'd5, 12'd5},
    {2'b01, 12'd1, 12'd4}, {2'b01, 12'd4, 12'd4},
    {2'b01, 12'd5, 12'd8}, {2'b10, 12'd3, 12'd8},
    {2'b10, 12'd9, 12'd16}, {2'b11, 12'd6, 12'd6}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [11:0] c, input bit d);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = {a, 2'b00, c, d, 15'h0};
    @(negedge clk);
    cfg_we = 0;
    cfg_wdata = '0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    dat_push = 1;
    dat_wdata = w;
    @(negedge clk);
    dat_push = 0;
  endtask

  task automatic push_len(input logic [11:0] l);
    @(negedge clk);
    sts_push = 1;
    sts_len = l;
    @(negedge clk);
    sts_push = 0;
  endtask

  task automatic rd(output logic [31:0] d, output logic l);
    @(negedge clk);
    host_rd = 1;
    #1;
    d = host_rdata;
    l = host_last;
    @(posedge clk);
    #1;
    host_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 0 && !rd_valid && !dma_irq && !dat_full, "R1 reset state",
        {cfg_rdata[31:3], rd_valid, dma_irq, dat_full}, 32'h0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0]  a;
      logic [11:0] len, tot;
      a = VEC[v][25:24];
      len = VEC[v][23:12];
      tot = VEC[v][11:0];
      cfg_wr(a, 12'hFFF, 0);
      for (int k = 0; k < int'(len); k++) push_word({8'hA0, 8'(v), 16'(k)});
      push_len(len);
      for (int k = 0; k < int'(tot); k++) begin
        logic [31:0] ed;
        ed = (k < int'(len)) ? {8'hA0, 8'(v), 16'(k)} : 32'h0;
        rd(d, l);
        chk(d == ed, (k < int'(len)) ? "R2 data order" : ((a == 2'b11) ? "R4 reserved align" : "R3 pad zero"), d, ed);
        chk(l == (k == int'(tot) - 1), "R9 last marker", 32'(l), 32'(k == int'(tot) - 1));
      end
      @(negedge clk);
      chk(!rd_valid, "R3 pad length ends buffer", 32'(rd_valid), 0);
      chk(cfg_rdata[27:16] == 12'hFFF - tot, "R6 count per read", 32'(cfg_rdata[27:16]), 32'(12'hFFF - tot));
    end

    // R7: count 3, 1-word packet at 16-byte alignment (4 reads)
    cfg_wr(2'b01, 12'd3, 0);
    push_word(32'h1111_0000);
    push_len(12'd1);
    rd(d, l);
    rd(d, l);
    chk(!dma_irq, "R7 no early pulse", 32'(dma_irq), 0);
    rd(d, l);
    chk(dma_irq, "R7 pulse after 1->0", 32'(dma_irq), 1);
    rd(d, l);
    chk(!dma_irq && cfg_rdata[27:16] == 0, "R7 no pulse at zero", {cfg_rdata[27:16], 3'b0, dma_irq}, 0);

    // R6 rewrite; R5 align change mid-packet
    cfg_wr(2'b00, 12'd10, 0);
    push_word(32'h2222_0000);
    push_word(32'h2222_0001);
    push_len(12'd2);
    rd(d, l);
    chk(!l && d == 32'h2222_0000, "R5 first word", d, 32'h2222_0000);
    cfg_wr(2'b01, 12'd5, 0);
    chk(cfg_rdata[27:16] == 5, "R6 rewrite replaces", 32'(cfg_rdata[27:16]), 5);
    rd(d, l);
    chk(l && d == 32'h2222_0001, "R5 align held for packet", {d[31:1], l}, 32'h2222_0001);
    chk(cfg_rdata[27:16] == 4, "R6 decrement after rewrite", 32'(cfg_rdata[27:16]), 4);
    @(negedge clk);
    chk(!rd_valid, "R5 no filler added", 32'(rd_valid), 0);

    // R10 ignored read
    @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk(cfg_rdata[27:16] == 4, "R10 ignored read", 32'(cfg_rdata[27:16]), 4);

    // R8 discard
    for (int k = 0; k < 16; k++) push_word(32'h3333_0000 + k);
    push_len(12'd3);
    chk(dat_full && rd_valid, "R8 before discard", {dat_full, rd_valid}, 2'b11);
    cfg_wr(2'b00, 12'd0, 1);
    chk(!dat_full && !rd_valid, "R8 queues emptied", {dat_full, rd_valid}, 0);
    chk(cfg_rdata[15] == 0, "R8 bit reads zero", 32'(cfg_rdata[15]), 0);
    push_word(32'h4444_AAAA);
    push_len(12'd1);
    rd(d, l);
    chk(d == 32'h4444_AAAA && l, "R8 fresh data after discard", d, 32'h4444_AAAA);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule